// File: doc/BRIEF.md
# Two-Wire Register Access Slave

This block is the slave end of an open-drain, two-wire serial control port. A host uses it to read and write a bank of 16-bit registers that sit outside the block. The bank is reached through a register port made of a pointer output, a combinational read-data input and a one-cycle write strobe. The clock and data lines are brought into the system clock domain. The block finds start, repeated-start and stop conditions and checks a 7-bit device identifier. It then runs the byte protocol and acknowledges by pulling the data line low through an output-enable.

In a write, the host sends the identifier with the direction bit clear, then a register pointer, then words. Each word is two bytes, most significant byte first. To read, the host sets the pointer the same way and issues a repeated start with the direction bit set. The host then clocks out words and acknowledges each byte. A not-acknowledge ends the burst. The pointer advances after every complete word, so bursts continue through consecutive registers and wrap at the top of the address space.

Top module: `twi_reg_slave`

## Requirements
- R1: A data-line fall while the clock line is high is a start condition and a data-line rise while it is high is a stop condition. A start in any state, including mid-transaction (repeated start), restarts identifier reception. The block changes `sda_oe` only while the clock line is low.
- R2: When bits 7..1 of the first byte after a start equal the parameter `DEV_ID`, the block asserts `sda_oe` for the acknowledge (ninth) clock. Bit 0 of that byte selects the direction, 0 for write and 1 for read.
- R3: When the identifier does not match, the block gives no acknowledge. It does not drive the line and makes no register write until the next start.
- R4: In a write, the byte after the identifier is acknowledged and becomes the register pointer on `reg_addr`.
- R5: Each following byte pair is acknowledged byte by byte, high byte first. After the low byte, `reg_wr` pulses for exactly one clock with `reg_wr_data` = {high, low} at the pointer shown on `reg_addr`.
- R6: A stop after only the high byte of a word writes nothing.
- R7: The pointer increments by one after each complete word, read or write, and wraps from 0xFF to 0x00.
- R8: In a read, the block drives the high byte and then the low byte of `reg_rd_data` at the pointer, most significant bit first. A driven 0 is `sda_oe` = 1. The block releases the line during the host's acknowledge bit.
- R9: A host acknowledge (line low) after a read byte continues the burst. A not-acknowledge (line high) ends it, and the block stays released until the next start.
- R10: After reset `sda_oe` and `reg_wr` are 0 and the pointer is 0. A read issued directly after a start returns the word at the current pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level as seen on the bus |
| sda_oe | output | 1 | 1 pulls the data line low |
| reg_addr | output | ADDR_W | Register pointer for reads and writes |
| reg_rd_data | input | 16 | Read data of the register at `reg_addr` |
| reg_wr | output | 1 | One-clock write strobe |
| reg_wr_data | output | 16 | Word to write at `reg_addr` |

## Verification
The assertions check several rules on every cycle. The output-enable moves only while the synchronized clock line is low. A start always leads to identifier reception. The block stays silent while idle and during the host's acknowledge slot. Write strobes are single pulses, and a write burst steps the pointer by exactly one. Only the bench scenarios can show that the words land at the right registers, including the wrap at 0xFF and the ignored partial word. The same holds for a wrong identifier leaving the bank untouched and for the bit order of read bytes against the bench's own copy of the register contents.

// File: rtl/twi_pkg.sv
// Shared types for the two-wire register slave.
// Assumes 8-bit bytes and 16-bit registers carried as two bytes.
package twi_pkg;
    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV, ST_DEV_ACK,
        ST_ADR, ST_ADR_ACK,
        ST_WHI, ST_WHI_ACK,
        ST_WLO, ST_WLO_ACK,
        ST_RHI, ST_RHI_ACK,
        ST_RLO, ST_RLO_ACK
    } twi_state_e;
endpackage

// File: rtl/twi_line_sync.sv
// Brings the serial clock and data lines into the system clock domain and
// flags clock edges and start/stop conditions, one cycle wide each.
// Assumes SYNC_STAGES >= 2 and both lines idle high.
module twi_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [SYNC_STAGES-1:0] scl_chain, sda_chain;
    logic scl_prev, sda_prev;

    // Shift both lines through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_chain <= '1;
            sda_chain <= '1;
        end else begin
            scl_chain <= {scl_chain[SYNC_STAGES-2:0], scl_i};
            sda_chain <= {sda_chain[SYNC_STAGES-2:0], sda_i};
        end
    end

    // Keep the previous synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_prev <= scl_chain[SYNC_STAGES-1];
            sda_prev <= sda_chain[SYNC_STAGES-1];
        end
    end

    // Decode edges and bus conditions from current and previous levels.
    always_comb begin
        scl_lvl   = scl_chain[SYNC_STAGES-1];
        sda_lvl   = sda_chain[SYNC_STAGES-1];
        scl_rise  = scl_lvl & ~scl_prev;
        scl_fall  = ~scl_lvl & scl_prev;
        start_det = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
        stop_det  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;
    end
endmodule

// File: rtl/twi_slave_fsm.sv
// Protocol engine: identifier match, pointer load, word writes and word
// reads with auto-increment. Acts on the synchronized events from the line
// synchronizer; all line changes are made on clock-fall events.
module twi_slave_fsm
    import twi_pkg::*;
#(
    parameter logic [6:0] DEV_ID = 7'h1A,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_lvl,
    input  logic              sda_lvl,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [WORD_W-1:0] rd_data,
    output logic              sda_oe,
    output logic [ADDR_W-1:0] ptr,
    output logic              wr_pulse,
    output logic [WORD_W-1:0] wr_word
);
    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

    twi_state_e        state;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] hi_byte;
    logic              rw_bit;
    logic              nack;

    // Main protocol sequencer: conditions first, then per-state bit handling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            bit_cnt  <= '0;
            shreg    <= '0;
            hi_byte  <= '0;
            rw_bit   <= 1'b0;
            nack     <= 1'b0;
            sda_oe   <= 1'b0;
            ptr      <= '0;
            wr_pulse <= 1'b0;
            wr_word  <= '0;
        end else begin
            wr_pulse <= 1'b0;
            if (start_det) begin
                state   <= ST_DEV;
                bit_cnt <= '0;
                sda_oe  <= 1'b0;
            end else if (stop_det) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
            end else begin
                case (state)
                    ST_DEV, ST_ADR, ST_WHI, ST_WLO: begin
                        if (scl_rise && bit_cnt < FULL) begin
                            shreg   <= {shreg[BYTE_W-2:0], sda_lvl};
                            bit_cnt <= bit_cnt + 1'b1;
                        end else if (scl_fall && bit_cnt == FULL) begin
                            bit_cnt <= '0;
                            sda_oe  <= 1'b1;
                            case (state)
                                ST_DEV: begin
                                    if (shreg[BYTE_W-1:1] == DEV_ID) begin
                                        rw_bit <= shreg[0];
                                        state  <= ST_DEV_ACK;
                                    end else begin
                                        sda_oe <= 1'b0;
                                        state  <= ST_IDLE;
                                    end
                                end
                                ST_ADR: begin
                                    ptr   <= ADDR_W'(shreg);
                                    state <= ST_ADR_ACK;
                                end
                                ST_WHI: begin
                                    hi_byte <= shreg;
                                    state   <= ST_WHI_ACK;
                                end
                                default: begin
                                    wr_pulse <= 1'b1;
                                    wr_word  <= {hi_byte, shreg};
                                    state    <= ST_WLO_ACK;
                                end
                            endcase
                        end
                    end
                    ST_DEV_ACK, ST_ADR_ACK, ST_WHI_ACK, ST_WLO_ACK: begin
                        if (scl_fall) begin
                            sda_oe  <= 1'b0;
                            bit_cnt <= '0;
                            case (state)
                                ST_DEV_ACK: begin
                                    if (rw_bit) begin
                                        shreg  <= rd_data[WORD_W-1:BYTE_W];
                                        sda_oe <= ~rd_data[WORD_W-1];
                                        state  <= ST_RHI;
                                    end else begin
                                        state <= ST_ADR;
                                    end
                                end
                                ST_ADR_ACK: state <= ST_WHI;
                                ST_WHI_ACK: state <= ST_WLO;
                                default: begin
                                    ptr   <= ptr + 1'b1;
                                    state <= ST_WHI;
                                end
                            endcase
                        end
                    end
                    ST_RHI, ST_RLO: begin
                        if (scl_fall) begin
                            if (bit_cnt == LAST) begin
                                bit_cnt <= '0;
                                sda_oe  <= 1'b0;
                                if (state == ST_RLO) begin
                                    ptr   <= ptr + 1'b1;
                                    state <= ST_RLO_ACK;
                                end else begin
                                    state <= ST_RHI_ACK;
                                end
                            end else begin
                                bit_cnt <= bit_cnt + 1'b1;
                                shreg   <= {shreg[BYTE_W-2:0], 1'b0};
                                sda_oe  <= ~shreg[BYTE_W-2];
                            end
                        end
                    end
                    ST_RHI_ACK, ST_RLO_ACK: begin
                        if (scl_rise) begin
                            nack <= sda_lvl;
                        end else if (scl_fall) begin
                            bit_cnt <= '0;
                            if (nack) begin
                                state <= ST_IDLE;
                            end else if (state == ST_RHI_ACK) begin
                                shreg  <= rd_data[BYTE_W-1:0];
                                sda_oe <= ~rd_data[BYTE_W-1];
                                state  <= ST_RLO;
                            end else begin
                                shreg  <= rd_data[WORD_W-1:BYTE_W];
                                sda_oe <= ~rd_data[WORD_W-1];
                                state  <= ST_RHI;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R1: the line enable only moves while the clock line is low.
    assert_oe_moves_scl_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !scl_lvl);

    // R1: every start condition restarts identifier reception.
    assert_start_enters_dev_R1: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state == ST_DEV));

    // R2: acknowledge of the identifier is driven while the clock is high.
    assert_dev_ack_driven_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DEV_ACK && scl_lvl) |-> sda_oe);

    // R3: an idle (unaddressed) slave never pulls the line.
    assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sda_oe);

    // R5: write strobe lasts one clock.
    assert_wr_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pulse |=> !wr_pulse);

    // R7: a finished write word steps the pointer by exactly one.
    assert_ptr_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == ST_WLO_ACK && state == ST_WHI) |-> (ptr == ADDR_W'($past(ptr) + 1'b1)));

    // R8: line released while the host acknowledges a read byte.
    assert_release_host_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RHI_ACK || state == ST_RLO_ACK) |-> !sda_oe);
endmodule

// File: rtl/twi_reg_slave.sv
// Top of the two-wire register slave: line synchronizer plus protocol
// engine. The register bank is external, read combinationally through
// reg_addr/reg_rd_data and written on the reg_wr strobe.
module twi_reg_slave
    import twi_pkg::*;
#(
    parameter logic [6:0] DEV_ID = 7'h1A,
    parameter int ADDR_W = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    output logic [ADDR_W-1:0] reg_addr,
    input  logic [WORD_W-1:0] reg_rd_data,
    output logic              reg_wr,
    output logic [WORD_W-1:0] reg_wr_data
);
    logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;

    twi_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_lvl   (scl_lvl),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    twi_slave_fsm #(.DEV_ID(DEV_ID), .ADDR_W(ADDR_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_lvl   (scl_lvl),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .rd_data   (reg_rd_data),
        .sda_oe    (sda_oe),
        .ptr       (reg_addr),
        .wr_pulse  (reg_wr),
        .wr_word   (reg_wr_data)
    );
endmodule

// File: tb/test_twi_reg_slave.sv
`timescale 1ns/1ps
// Bench: behavioural host plus a per-clock model of who may pull the line.
module test_twi_reg_slave;
    localparam int CLK_PERIOD = 10;
    localparam int Q = 5;
    localparam logic [6:0] ID = 7'h1A;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic host_low = 1'b0;
    logic sda_oe, reg_wr;
    logic [7:0] reg_addr;
    logic [15:0] reg_rd_data, reg_wr_data;
    logic sda_bus;

    logic [15:0] mem [256];
    logic [15:0] exp_mem [256];
    int checks = 0, fails = 0, wr_count = 0;
    logic exp_oe = 1'b0;
    logic mon_en = 1'b0;
    string mon_req = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;
    assign sda_bus = (host_low || sda_oe) ? 1'b0 : 1'b1;
    assign reg_rd_data = mem[reg_addr];

    twi_reg_slave #(.DEV_ID(ID)) i_twi_reg_slave (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
        .sda_oe(sda_oe), .reg_addr(reg_addr), .reg_rd_data(reg_rd_data),
        .reg_wr(reg_wr), .reg_wr_data(reg_wr_data));

    // Register bank served to the block; counts write strobes.
    always @(posedge clk) begin
        if (reg_wr) begin
            mem[reg_addr] <= reg_wr_data;
            wr_count++;
        end
    end

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Per-clock model comparison: while the clock line is high, sda_oe must equal the model.
    always @(posedge clk) begin
        #1;
        if (mon_en && scl) begin
            checks++;
            if (sda_oe !== exp_oe) begin
                fails++;
                $display("FAIL %s line drive at %0t: actual %0b expected %0b", mon_req, $time, sda_oe, exp_oe);
            end
        end
    end

    task automatic wait_q();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        mon_req = "R1"; exp_oe = 1'b0;
        host_low = 1'b0; wait_q();
        scl = 1'b1; wait_q();
        host_low = 1'b1; wait_q();
        scl = 1'b0;
    endtask

    task automatic bus_stop();
        mon_req = "R1"; exp_oe = 1'b0;
        host_low = 1'b1; wait_q();
        scl = 1'b1; wait_q();
        host_low = 1'b0; wait_q(); wait_q();
    endtask

    task automatic write_bit(input logic b);
        wait_q(); host_low = ~b;
        wait_q(); scl = 1'b1;
        wait_q(); wait_q(); scl = 1'b0;
    endtask

    task automatic read_bit(output logic b);
        wait_q(); host_low = 1'b0;
        wait_q(); scl = 1'b1;
        wait_q(); b = sda_bus;
        wait_q(); scl = 1'b0;
    endtask

    // Host sends a byte; exp_ack says whether the slave should acknowledge.
    task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string req);
        logic a;
        mon_req = "R1"; exp_oe = 1'b0;
        for (int i = 7; i >= 0; i--) write_bit(b[i]);
        mon_req = req; exp_oe = exp_ack;
        read_bit(a);
        exp_oe = 1'b0; mon_req = "R1";
        check(a == ~exp_ack, req, "acknowledge bit", a, ~exp_ack);
    endtask

    // Host reads a byte and then acknowledges (ack=1) or not.
    task automatic recv_byte(input logic [7:0] expb, input bit ack, input string req);
        logic [7:0] got;
        logic b;
        mon_req = req;
        for (int i = 7; i >= 0; i--) begin
            exp_oe = ~expb[i];
            read_bit(b);
            got[i] = b;
        end
        exp_oe = 1'b0; mon_req = "R1";
        write_bit(~ack);
        check(got == expb, req, "read byte", got, expb);
    endtask

    task automatic write_words(input logic [7:0] addr, input int n, input logic [15:0] base);
        bus_start();
        send_byte({ID, 1'b0}, 1'b1, "R2");
        send_byte(addr, 1'b1, "R4");
        for (int k = 0; k < n; k++) begin
            logic [15:0] w;
            w = base + 16'(k * 16'h1111);
            send_byte(w[15:8], 1'b1, "R5");
            send_byte(w[7:0], 1'b1, "R5");
            exp_mem[8'(addr + k)] = w;
        end
        bus_stop();
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: run did not finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin : main
        int wc;
        for (int i = 0; i < 256; i++) begin
            mem[i] = 16'(i * 37 + 16'h5A00);
            exp_mem[i] = 16'(i * 37 + 16'h5A00);
        end
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state at the ports
        check(sda_oe == 1'b0, "R10", "sda_oe after reset", sda_oe, 0);
        check(reg_wr == 1'b0, "R10", "reg_wr after reset", reg_wr, 0);
        check(reg_addr == 8'h00, "R10", "pointer after reset", reg_addr, 0);
        mon_en = 1'b1;

        // R10/R8: read at the current pointer straight after a start
        bus_start();
        send_byte({ID, 1'b1}, 1'b1, "R2");
        recv_byte(exp_mem[0][15:8], 1'b1, "R10");
        recv_byte(exp_mem[0][7:0], 1'b0, "R10");
        bus_stop();

        // R4/R5: single word write
        wc = wr_count;
        write_words(8'h10, 1, 16'hBEEF);
        check(mem[8'h10] == exp_mem[8'h10], "R5", "word at 0x10", mem[8'h10], exp_mem[8'h10]);
        check(wr_count == wc + 1, "R5", "write strobes", wr_count, wc + 1);

        // R7: burst write across the wrap
        wc = wr_count;
        write_words(8'hFE, 3, 16'h1111);
        check(mem[8'hFE] == exp_mem[8'hFE], "R7", "word at 0xFE", mem[8'hFE], exp_mem[8'hFE]);
        check(mem[8'hFF] == exp_mem[8'hFF], "R7", "word at 0xFF", mem[8'hFF], exp_mem[8'hFF]);
        check(mem[8'h00] == exp_mem[8'h00], "R7", "word at 0x00 after wrap", mem[8'h00], exp_mem[8'h00]);
        check(wr_count == wc + 3, "R7", "write strobes in burst", wr_count, wc + 3);

        // R6: stop after a lone high byte
        wc = wr_count;
        bus_start();
        send_byte({ID, 1'b0}, 1'b1, "R2");
        send_byte(8'h20, 1'b1, "R4");
        send_byte(8'hAA, 1'b1, "R6");
        bus_stop();
        check(mem[8'h20] == exp_mem[8'h20], "R6", "word at 0x20 untouched", mem[8'h20], exp_mem[8'h20]);
        check(wr_count == wc, "R6", "no write strobe", wr_count, wc);

        // R3: wrong identifier, the rest of the transfer ignored
        wc = wr_count;
        bus_start();
        send_byte({ID ^ 7'h01, 1'b0}, 1'b0, "R3");
        send_byte(8'h30, 1'b0, "R3");
        send_byte(8'h12, 1'b0, "R3");
        send_byte(8'h34, 1'b0, "R3");
        bus_stop();
        check(mem[8'h30] == exp_mem[8'h30], "R3", "word at 0x30 untouched", mem[8'h30], exp_mem[8'h30]);
        check(wr_count == wc, "R3", "no write strobe", wr_count, wc);

        // R1/R8/R7/R9: pointer set, repeated start, burst read across wrap, NACK ends
        bus_start();
        send_byte({ID, 1'b0}, 1'b1, "R2");
        send_byte(8'hFE, 1'b1, "R4");
        bus_start();
        send_byte({ID, 1'b1}, 1'b1, "R1");
        recv_byte(exp_mem[8'hFE][15:8], 1'b1, "R8");
        recv_byte(exp_mem[8'hFE][7:0], 1'b1, "R8");
        recv_byte(exp_mem[8'hFF][15:8], 1'b1, "R9");
        recv_byte(exp_mem[8'hFF][7:0], 1'b1, "R9");
        recv_byte(exp_mem[8'h00][15:8], 1'b1, "R7");
        recv_byte(exp_mem[8'h00][7:0], 1'b0, "R7");
        recv_byte(8'hFF, 1'b0, "R9");
        bus_stop();
        check(reg_addr == 8'h01, "R7", "pointer after read burst", reg_addr, 1);

        mon_en = 1'b0;
        repeat (4) @(negedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule